// File: doc/BRIEF.md
# Timer Capture/Compare Register Channel

This block is a single general register of a timer channel. A 4-bit mode field makes it either an output compare register or an input capture register. As a compare register, it watches a free-running counter value supplied from outside. When the counter equals the stored value, it raises a match event. On the next clock edge it updates a timer output pin: it sets the pin, clears it or toggles it.

As a capture register, it latches the counter value into itself and raises a sticky capture flag. A capture can come from either of two sources:
- an edge on an external pin, which is synchronized with two flops first;
- each count event of a neighbouring counter.

A buffer-mode flag turns the register into a plain storage word, and no capture or compare takes place.

Software reaches the block over a small register bus. It can write and read the register value, the mode field and the status flag, and it clears the flag by writing a one to it. The counter, the prescaler and any interrupt logic are outside this block.

Top module: `tmr_ccr`

## Requirements
- R1: After reset, the register value, the mode field, the capture flag, the output pin and its output enable are all 0.
- R2: The bus uses three addresses. Address 0 reads and writes the register value. Address 1 holds the mode field in data bits [3:0], and the upper bits read as 0. Address 2 holds the capture flag in bit 0. Reads are combinational from `bus_addr`.
- R3: `match_evt` is high in any cycle where the mode field bit 3 is 0, buffer mode is off and `cnt_val` equals the register value. It is low in capture mode.
- R4: On the clock edge after a match, the pin follows mode bits [1:0]: 00 leaves it unchanged, 01 drives it to 0, 10 drives it to 1, and 11 inverts it.
- R5: A write of a mode value with bit 3 = 0 loads the output pin with mode bit 2 on that same clock edge. A load from a mode write takes priority over a match action.
- R6: `tout_oe` is 1 only when mode bit 3 is 0 and mode bits [1:0] are not 00.
- R7: In capture mode with mode bit 2 = 0, the capture source is `cap_pin`, and mode bits [1:0] pick the edge: 00 rising, 01 falling, 1x both. The capture lands on the third rising clock edge after the pin changes.
- R8: In capture mode with mode bit 2 = 1, each cycle with `nbr_cnt_evt` high captures on that clock edge. Mode bits [1:0] and `cap_pin` have no effect.
- R9: Neighbour-event capture does not occur while `nbr_psc_sel` is 000.
- R10: With `buf_mode` high, no match and no capture occur whatever the mode field holds, and bus writes still store the register value.
- R11: A capture loads `cnt_val` into the register and sets the flag. A write of bit 0 = 1 to address 2 clears the flag, a write of 0 leaves it set, and a capture in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Running counter value |
| cap_pin | input | 1 | External capture pin, asynchronous |
| nbr_cnt_evt | input | 1 | Count-up/count-down strobe of the neighbouring counter |
| nbr_psc_sel | input | PSC_W | Prescaler select of the neighbouring counter |
| buf_mode | input | 1 | Buffer-mode flag that suppresses capture and compare |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 2 | Bus register address |
| bus_wdata | input | CNT_W | Bus write data |
| bus_rdata | output | CNT_W | Bus read data |
| tout | output | 1 | Timer output pin level |
| tout_oe | output | 1 | Timer output pin enable |
| match_evt | output | 1 | Compare match flag |
| cap_evt | output | 1 | Capture event flag |

## Verification
Compare mode is driven from a vector table. The table crosses every pin action with both initial levels, and includes hit and miss counter values and the all-ones register value. This separates the initial-level load from the action applied on a match. Pin capture is tried with each edge selection against both pin directions, and the register is read one edge before the capture is due, which exposes a wrong synchronizer depth. Neighbour-event capture is run with both a divided and an undivided prescaler select and with the pin toggling, and buffer mode is applied over both a capture mode and a matching compare mode.

// File: rtl/tmr_ccr_pkg.sv
package tmr_ccr_pkg;

  localparam int BUS_AW = 2;

  localparam logic [BUS_AW-1:0] ADR_VAL  = 2'd0;
  localparam logic [BUS_AW-1:0] ADR_MODE = 2'd1;
  localparam logic [BUS_AW-1:0] ADR_STAT = 2'd2;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } cmp_act_e;

  // Next pin level after a match under the given action code.
  function automatic logic cmp_next_level(input logic cur, input logic [1:0] act);
    case (cmp_act_e'(act))
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

  // Edge qualifier for pin capture: 00 rising, 01 falling, 1x both.
  function automatic logic pin_edge_hit(input logic [1:0] sel, input logic rise,
                                        input logic fall);
    if (sel[1]) return rise | fall;
    if (sel[0]) return fall;
    return rise;
  endfunction

endpackage

// File: rtl/tmr_ccr_sync.sv
module tmr_ccr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  localparam int PW = STAGES + 1;

  logic [PW-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[PW-2:0], din};
  end

  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/tmr_ccr_cmp.sv
module tmr_ccr_cmp
  import tmr_ccr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] gr_val,
  input  logic [3:0]       mode,
  input  logic             buf_mode,
  input  logic             mode_wr,
  input  logic [3:0]       mode_wdata,
  output logic             match_evt,
  output logic             tout,
  output logic             tout_oe
);
  logic tout_q;

  assign match_evt = ~buf_mode & ~mode[3] & (cnt_val == gr_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tout_q <= 1'b0;
    end else if (mode_wr && !mode_wdata[3]) begin
      tout_q <= mode_wdata[2];
    end else if (match_evt) begin
      tout_q <= cmp_next_level(tout_q, mode[1:0]);
    end
  end

  assign tout    = tout_q;
  assign tout_oe = ~mode[3] & (mode[1:0] != ACT_NONE);
endmodule

// File: rtl/tmr_ccr_cap.sv
module tmr_ccr_cap
  import tmr_ccr_pkg::*;
#(
  parameter int PSC_W = 3
) (
  input  logic [3:0]       mode,
  input  logic             buf_mode,
  input  logic             pin_rise,
  input  logic             pin_fall,
  input  logic             nbr_cnt_evt,
  input  logic [PSC_W-1:0] nbr_psc_sel,
  output logic             pin_cap,
  output logic             nbr_cap,
  output logic             cap_evt
);
  logic nbr_divided;

  assign nbr_divided = (nbr_psc_sel != '0);
  assign pin_cap = mode[3] & ~mode[2] & pin_edge_hit(mode[1:0], pin_rise, pin_fall);
  assign nbr_cap = mode[3] & mode[2] & nbr_cnt_evt & nbr_divided;
  assign cap_evt = ~buf_mode & (pin_cap | nbr_cap);
endmodule

// File: rtl/tmr_ccr.sv
module tmr_ccr
  import tmr_ccr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cap_pin,
  input  logic             nbr_cnt_evt,
  input  logic [PSC_W-1:0] nbr_psc_sel,
  input  logic             buf_mode,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             tout,
  output logic             tout_oe,
  output logic             match_evt,
  output logic             cap_evt
);
  localparam int MODE_W = 4;

  logic [CNT_W-1:0]  gr_q;
  logic [MODE_W-1:0] mode_q;
  logic              cap_flag_q;
  logic              wr_val, wr_mode, wr_stat;
  logic              pin_rise, pin_fall, pin_cap, nbr_cap;

  assign wr_val  = bus_wr & (bus_addr == ADR_VAL);
  assign wr_mode = bus_wr & (bus_addr == ADR_MODE);
  assign wr_stat = bus_wr & (bus_addr == ADR_STAT);

  tmr_ccr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n(rst_n),
    .din (cap_pin),
    .rise(pin_rise),
    .fall(pin_fall)
  );

  tmr_ccr_cap #(.PSC_W(PSC_W)) u_cap (
    .mode       (mode_q),
    .buf_mode   (buf_mode),
    .pin_rise   (pin_rise),
    .pin_fall   (pin_fall),
    .nbr_cnt_evt(nbr_cnt_evt),
    .nbr_psc_sel(nbr_psc_sel),
    .pin_cap    (pin_cap),
    .nbr_cap    (nbr_cap),
    .cap_evt    (cap_evt)
  );

  tmr_ccr_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_val   (cnt_val),
    .gr_val    (gr_q),
    .mode      (mode_q),
    .buf_mode  (buf_mode),
    .mode_wr   (wr_mode),
    .mode_wdata(bus_wdata[MODE_W-1:0]),
    .match_evt (match_evt),
    .tout      (tout),
    .tout_oe   (tout_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gr_q       <= '0;
      mode_q     <= '0;
      cap_flag_q <= 1'b0;
    end else begin
      if (cap_evt)     gr_q <= cnt_val;
      else if (wr_val) gr_q <= bus_wdata;
      if (wr_mode) mode_q <= bus_wdata[MODE_W-1:0];
      if (cap_evt)                     cap_flag_q <= 1'b1;
      else if (wr_stat && bus_wdata[0]) cap_flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_VAL:  bus_rdata = gr_q;
      ADR_MODE: bus_rdata = {{(CNT_W-MODE_W){1'b0}}, mode_q};
      ADR_STAT: bus_rdata = {{(CNT_W-1){1'b0}}, cap_flag_q};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_ccr_chk.sv
module tmr_ccr_chk
  import tmr_ccr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] gr_q,
  input logic [3:0]       mode_q,
  input logic             cap_flag_q,
  input logic             buf_mode,
  input logic [PSC_W-1:0] nbr_psc_sel,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic             match_evt,
  input logic             cap_evt,
  input logic             tout,
  input logic             tout_oe
);
  logic mode_wr;
  assign mode_wr = bus_wr & (bus_addr == ADR_MODE);

  a_r3_match_equal: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |-> (cnt_val == gr_q) && !mode_q[3]);

  a_r4_drive_low: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && mode_q[1:0] == 2'b01 && !mode_wr) |=> !tout);

  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && mode_q[1:0] == 2'b11 && !mode_wr) |=> tout != $past(tout));

  a_r5_init_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !bus_wdata[3]) |=> tout == $past(bus_wdata[2]));

  a_r6_oe_capture_off: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[3] |-> !tout_oe);

  a_r9_no_undivided: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && mode_q[3] && mode_q[2]) |-> nbr_psc_sel != '0);

  a_r10_buffer_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    buf_mode |-> !match_evt && !cap_evt);

  a_r11_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (gr_q == $past(cnt_val)) && cap_flag_q);

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag_q && !(bus_wr && bus_addr == ADR_STAT && bus_wdata[0])) |=> cap_flag_q);
endmodule

bind tmr_ccr tmr_ccr_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_val    (cnt_val),
  .gr_q       (gr_q),
  .mode_q     (mode_q),
  .cap_flag_q (cap_flag_q),
  .buf_mode   (buf_mode),
  .nbr_psc_sel(nbr_psc_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .match_evt  (match_evt),
  .cap_evt    (cap_evt),
  .tout       (tout),
  .tout_oe    (tout_oe)
);

// File: tb/tmr_ccr_bench.sv
module tmr_ccr_bench;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cnt_val = '0;
  logic          cap_pin = 1'b0;
  logic          nbr_cnt_evt = 1'b0;
  logic [2:0]    nbr_psc_sel = 3'b001;
  logic          buf_mode = 1'b0;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic          tout, tout_oe, match_evt, cap_evt;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  tmr_ccr u_tmr_ccr (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cap_pin(cap_pin),
    .nbr_cnt_evt(nbr_cnt_evt), .nbr_psc_sel(nbr_psc_sel), .buf_mode(buf_mode),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tout(tout), .tout_oe(tout_oe),
    .match_evt(match_evt), .cap_evt(cap_evt)
  );

  typedef struct packed {
    logic [3:0]    mode;
    logic [CW-1:0] val;
    logic [CW-1:0] cnt;
    logic          hit;
    logic          pin;
  } vec_t;

  // mode, register, counter, expected match, expected pin after the edge
  localparam vec_t VECS [9] = '{
    '{4'b0001, 16'd10,    16'd10,    1'b1, 1'b0},
    '{4'b0101, 16'd10,    16'd10,    1'b1, 1'b0},
    '{4'b0010, 16'd33,    16'd33,    1'b1, 1'b1},
    '{4'b0011, 16'd33,    16'd33,    1'b1, 1'b1},
    '{4'b0111, 16'd7,     16'd7,     1'b1, 1'b0},
    '{4'b0100, 16'd7,     16'd7,     1'b1, 1'b1},
    '{4'b0110, 16'd5,     16'd6,     1'b0, 1'b1},
    '{4'b0001, 16'd20,    16'd19,    1'b0, 1'b0},
    '{4'b0011, 16'hFFFF,  16'hFFFF,  1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [CW-1:0] d);
    bus_addr = a; #0.5;
    d = bus_rdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [CW-1:0] r;
    cycles(3);
    // R1 reset state
    rd(2'd0, r); check("R1 value", r, 0);
    rd(2'd1, r); check("R1 mode", r, 0);
    rd(2'd2, r); check("R1 flag", r, 0);
    check("R1 tout", tout, 0);
    check("R1 oe", tout_oe, 0);
    rst_n = 1'b1;
    cycles(2);

    // R3 R4 R5 R6 compare table
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      cnt_val = ~v.val;
      wr(2'd0, v.val);
      wr(2'd1, {12'd0, v.mode});
      check("R5 init level", tout, v.mode[2]);
      check("R6 oe", tout_oe, v.mode[1:0] != 2'b00);
      cnt_val = v.cnt; #1;
      check("R3 match", match_evt, v.hit);
      @(posedge clk); #1;
      check("R4 pin action", tout, v.pin);
    end

    // R2 readback
    cnt_val = 16'h0;
    wr(2'd0, 16'h1234);
    rd(2'd0, r); check("R2 value", r, 16'h1234);
    wr(2'd1, 16'hFFF8);
    rd(2'd1, r); check("R2 mode upper zero", r, 16'h0008);
    check("R3 no match in capture", match_evt, 0);
    check("R6 oe capture", tout_oe, 0);

    // R7 rising edge capture, sync latency
    cnt_val = 16'h0100;
    cap_pin = 1'b1;
    cycles(2);
    rd(2'd0, r); check("R7 not yet captured", r, 16'h1234);
    cycles(1);
    rd(2'd0, r); check("R7 rising capture", r, 16'h0100);
    rd(2'd2, r); check("R11 flag set", r, 1);
    wr(2'd2, 16'h0000);
    rd(2'd2, r); check("R11 write 0 keeps flag", r, 1);
    wr(2'd2, 16'h0001);
    rd(2'd2, r); check("R11 write 1 clears", r, 0);
    cnt_val = 16'h0200; cap_pin = 1'b0; cycles(4);
    rd(2'd0, r); check("R7 rising ignores fall", r, 16'h0100);
    rd(2'd2, r); check("R7 no flag on fall", r, 0);

    // R7 falling
    wr(2'd1, 16'h0009);
    cnt_val = 16'h0300; cap_pin = 1'b1; cycles(4);
    rd(2'd0, r); check("R7 falling ignores rise", r, 16'h0100);
    cnt_val = 16'h0400; cap_pin = 1'b0; cycles(4);
    rd(2'd0, r); check("R7 falling capture", r, 16'h0400);

    // R7 both edges
    wr(2'd1, 16'h000A);
    cnt_val = 16'h0500; cap_pin = 1'b1; cycles(4);
    rd(2'd0, r); check("R7 both rise", r, 16'h0500);
    cnt_val = 16'h0600; cap_pin = 1'b0; cycles(4);
    rd(2'd0, r); check("R7 both fall", r, 16'h0600);

    // R8 neighbour capture, low bits ignored, pin ignored
    wr(2'd2, 16'h0001);
    wr(2'd1, 16'h000F);
    cnt_val = 16'h0777; nbr_psc_sel = 3'b001;
    nbr_cnt_evt = 1'b1; cycles(1); nbr_cnt_evt = 1'b0;
    rd(2'd0, r); check("R8 neighbour capture", r, 16'h0777);
    rd(2'd2, r); check("R8 flag", r, 1);
    cnt_val = 16'h0999; cap_pin = 1'b1; cycles(4);
    cap_pin = 1'b0; cycles(4);
    rd(2'd0, r); check("R8 pin ignored", r, 16'h0777);

    // R9 undivided neighbour clock
    nbr_psc_sel = 3'b000; cnt_val = 16'h0888;
    nbr_cnt_evt = 1'b1; cycles(2); nbr_cnt_evt = 1'b0;
    rd(2'd0, r); check("R9 suppressed", r, 16'h0777);
    nbr_psc_sel = 3'b001;

    // R10 buffer mode
    wr(2'd2, 16'h0001);
    buf_mode = 1'b1;
    wr(2'd1, 16'h0008);
    cnt_val = 16'h0AAA; cap_pin = 1'b1; cycles(4);
    cap_pin = 1'b0; cycles(4);
    rd(2'd0, r); check("R10 no capture", r, 16'h0777);
    rd(2'd2, r); check("R10 no flag", r, 0);
    wr(2'd0, 16'hABCD);
    rd(2'd0, r); check("R10 buffer write", r, 16'hABCD);
    wr(2'd1, 16'h0003);
    cnt_val = 16'hABCD; #1;
    check("R10 no match", match_evt, 0);
    cycles(1);
    check("R10 pin held", tout, 0);
    buf_mode = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule